// File: doc/BRIEF.md
# Load-Store Address Generation Unit

This block turns the operand fields of a single-register load or store into everything a memory port needs. From a base value and an offset, which is a zero-extended immediate, a register value or a register value shifted left, it forms the sum or the difference. It then chooses whether the access uses that result or the untouched base. It also produces the value to write back into the base register and decides whether that write happens. For the access itself it gives the byte-lane enables, a misalignment flag and the store data copied into every lane that the access can reach.

A second, independent path takes a raw little-endian memory word returned for a load. It picks out the addressed byte or halfword and sign- or zero-extends it to full width. Both paths are registered: a request presented with its valid high on one rising edge appears on the outputs after that edge, with a matching valid pulse. Reset is asserted asynchronously, and its release passes through a two-stage synchronizer, so the block accepts requests only from the third edge after `rst_n` rises.

Top module: `ls_agu`

## Requirements
- R1: With offset source code 0, the offset is `req_imm` zero-extended to the data width, and with add selected `rsp_wb_val` equals base plus that immediate, modulo 2^AW.
- R2: With offset source code 1 or 3, the offset is `req_idx` unshifted.
- R3: With offset source code 2, the offset is `req_idx` shifted left by `req_shamt` bits; for example a shift of 2 gives base + 4×index.
- R4: When `req_sub` is 1 the offset is subtracted from the base instead of added, modulo 2^AW.
- R5: Pre-index (`req_pre`=1) with `req_wb`=0: `rsp_addr` is base±offset and `rsp_wb_en` is 0.
- R6: Pre-index with `req_wb`=1: `rsp_addr` and `rsp_wb_val` are both base±offset and `rsp_wb_en` is 1.
- R7: Post-index (`req_pre`=0): `rsp_addr` is the unmodified base, `rsp_wb_val` is base±offset, and `rsp_wb_en` is 1 whatever `req_wb` holds.
- R8: Size codes are 0 byte, 1 halfword, 2 or 3 word. `rsp_misalign` is 1 for a halfword whose address bit 0 is set, or for a word whose address bits 1:0 are not both zero. A byte is never misaligned.
- R9: On an aligned access, lane bit i of `rsp_lane_en` covers byte address offset i (little-endian). A byte sets the single bit at the address offset, a halfword sets bits {a, a+1} with a the even offset, and a word sets all four bits. A misaligned access sets no lanes.
- R10: `rsp_st_data` carries `req_st_src[7:0]` in every lane for a byte, `req_st_src[15:0]` in every halfword for a halfword, and `req_st_src` unchanged for a word.
- R11: A load of a byte or halfword takes the lane chosen by `ld_addr_lo` from `ld_raw`, with the byte at the lowest address in bits 7:0. It sign-extends from bit 7 or bit 15 when `ld_signed` is 1 and zero-extends otherwise. A word load returns `ld_raw`.
- R12: After reset every output is 0. Each output valid is high exactly in the cycle after an edge at which its request valid was high, and results keep their value while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized |
| req_vld | input | 1 | Address request valid |
| req_base | input | AW | Base register value |
| req_imm | input | IMMW | Immediate offset |
| req_idx | input | AW | Index register value |
| req_shamt | input | SHW | Left shift applied to the index for code 2 |
| req_ofs_sel | input | 2 | Offset source: 0 immediate, 1/3 register, 2 scaled register |
| req_sub | input | 1 | 1 subtracts the offset |
| req_pre | input | 1 | 1 pre-index, 0 post-index |
| req_wb | input | 1 | Write-back request for pre-index |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| req_st_src | input | AW | Store data before lane steering |
| rsp_vld | output | 1 | Address result valid |
| rsp_addr | output | AW | Effective address |
| rsp_wb_val | output | AW | Value for the base register |
| rsp_wb_en | output | 1 | Base register write enable |
| rsp_lane_en | output | NB | Byte-lane enables |
| rsp_misalign | output | 1 | Address not aligned to the size |
| rsp_st_data | output | AW | Lane-steered store data |
| ld_vld | input | 1 | Load alignment request valid |
| ld_raw | input | AW | Raw memory word |
| ld_addr_lo | input | LOW | Low address bits of the load |
| ld_size | input | 2 | Load size, same codes as `req_size` |
| ld_signed | input | 1 | 1 sign-extends a sub-word load |
| ld_rdy | output | 1 | Aligned load data valid |
| ld_data | output | AW | Aligned, extended load data |

## Verification
The bench builds the block with its default parameters, a 32-bit data width and a 12-bit immediate. This makes reachable shift amounts up to 31, immediates up to 4095, and the full four-lane set of byte, halfword and word placements. With this width, additions and subtractions that cross zero or the top of the address space can be checked for wraparound, and sign extension can be checked from both bit 7 and bit 15 of every lane position.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

  typedef enum logic [1:0] {
    OFS_IMM    = 2'd0,
    OFS_REG    = 2'd1,
    OFS_SCALED = 2'd2,
    OFS_REG_ALT = 2'd3
  } ofs_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } acc_size_e;

  function automatic logic is_word(input logic [1:0] sz);
    return sz[1];
  endfunction

endpackage

// File: rtl/ls_agu_offset.sv
module ls_agu_offset #(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  parameter int SHW  = 5
) (
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   idx,
  input  logic [SHW-1:0]  shamt,
  input  logic [1:0]      sel,
  output logic [AW-1:0]   ofs
);
  import ls_agu_pkg::*;

  localparam int PADW = AW - IMMW;

  logic [AW-1:0] imm_ext;
  logic [AW-1:0] idx_scaled;

  assign imm_ext    = {{PADW{1'b0}}, imm};
  assign idx_scaled = idx << shamt;

  always_comb begin
    unique case (ofs_sel_e'(sel))
      OFS_IMM:    ofs = imm_ext;
      OFS_SCALED: ofs = idx_scaled;
      default:    ofs = idx;
    endcase
  end

endmodule

// File: rtl/ls_agu_addr.sv
module ls_agu_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] ofs,
  input  logic          sub,
  input  logic          pre,
  input  logic          wb_req,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_en
);

  logic [AW-1:0] ofs_signed;
  logic [AW-1:0] moved;

  // subtraction as addition of the two's complement keeps one adder
  assign ofs_signed = sub ? (~ofs + {{(AW-1){1'b0}}, 1'b1}) : ofs;
  assign moved      = base + ofs_signed;

  always_comb begin
    wb_val = moved;
    if (pre) begin
      addr  = moved;
      wb_en = wb_req;
    end else begin
      addr  = base;
      wb_en = 1'b1;
    end
  end

endmodule

// File: rtl/ls_agu_lanes.sv
module ls_agu_lanes #(
  parameter int AW = 32
) (
  input  logic [$clog2(AW/8)-1:0] lo,
  input  logic [1:0]              size,
  input  logic [AW-1:0]           st_src,
  output logic [AW/8-1:0]         lane_en,
  output logic                    misalign,
  output logic [AW-1:0]           st_data
);
  import ls_agu_pkg::*;

  localparam int NB  = AW / 8;
  localparam int LOW = $clog2(NB);

  logic            sz_byte;
  logic            sz_half;
  logic            sz_word;
  logic [NB-1:0]   lane_raw;
  logic [LOW-1:0]  lo_half;
  logic [LOW-1:0]  lo_word;

  assign sz_byte = (acc_size_e'(size) == SZ_BYTE);
  assign sz_half = (acc_size_e'(size) == SZ_HALF);
  assign sz_word = is_word(size);
  assign lo_half = lo >> 1;
  assign lo_word = lo >> 2;

  always_comb begin
    misalign = 1'b0;
    if (sz_half) misalign = lo[0];
    if (sz_word) misalign = lo[0] | lo[1];
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [LOW-1:0] BI = LOW'(i);
    localparam logic [LOW-1:0] HI = LOW'(i >> 1);
    localparam logic [LOW-1:0] WI = LOW'(i >> 2);
    localparam int HOFS = (i % 2) * 8;
    localparam int WOFS = (i % 4) * 8;

    assign lane_raw[i] = (sz_byte && lo == BI)      ||
                         (sz_half && lo_half == HI) ||
                         (sz_word && lo_word == WI);

    always_comb begin
      if (sz_byte)      st_data[8*i +: 8] = st_src[7:0];
      else if (sz_half) st_data[8*i +: 8] = st_src[HOFS +: 8];
      else              st_data[8*i +: 8] = st_src[WOFS +: 8];
    end
  end

  assign lane_en = misalign ? '0 : lane_raw;

endmodule

// File: rtl/ls_agu_ldalign.sv
module ls_agu_ldalign #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]           raw,
  input  logic [$clog2(AW/8)-1:0] lo,
  input  logic [1:0]              size,
  input  logic                    sgn,
  output logic [AW-1:0]           data
);
  import ls_agu_pkg::*;

  localparam int NB  = AW / 8;
  localparam int LOW = $clog2(NB);

  logic [LOW-1:0] sel;
  logic [AW-1:0]  shifted;
  logic [AW-1:0]  byte_v;
  logic [AW-1:0]  half_v;
  logic [AW-1:0]  word_v;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: sel = lo;
      SZ_HALF: sel = lo & ~LOW'(1);
      default: sel = lo & ~LOW'(3);
    endcase
  end

  assign shifted = raw >> {sel, 3'b000};
  assign byte_v  = {{(AW-8){sgn & shifted[7]}}, shifted[7:0]};
  assign half_v  = {{(AW-16){sgn & shifted[15]}}, shifted[15:0]};

  if (AW == 32) begin : g_word_full
    assign word_v = shifted;
  end else begin : g_word_ext
    assign word_v = {{(AW-32){sgn & shifted[31]}}, shifted[31:0]};
  end

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: data = byte_v;
      SZ_HALF: data = half_v;
      default: data = word_v;
    endcase
  end

endmodule

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  parameter int NB   = AW / 8,
  parameter int LOW  = $clog2(AW / 8),
  parameter int SHW  = $clog2(AW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [AW-1:0]   req_base,
  input  logic [IMMW-1:0] req_imm,
  input  logic [AW-1:0]   req_idx,
  input  logic [SHW-1:0]  req_shamt,
  input  logic [1:0]      req_ofs_sel,
  input  logic            req_sub,
  input  logic            req_pre,
  input  logic            req_wb,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_st_src,
  output logic            rsp_vld,
  output logic [AW-1:0]   rsp_addr,
  output logic [AW-1:0]   rsp_wb_val,
  output logic            rsp_wb_en,
  output logic [NB-1:0]   rsp_lane_en,
  output logic            rsp_misalign,
  output logic [AW-1:0]   rsp_st_data,
  input  logic            ld_vld,
  input  logic [AW-1:0]   ld_raw,
  input  logic [LOW-1:0]  ld_addr_lo,
  input  logic [1:0]      ld_size,
  input  logic            ld_signed,
  output logic            ld_rdy,
  output logic [AW-1:0]   ld_data
);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  // datapath
  logic [AW-1:0] ofs;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] wbv_d;
  logic          wben_d;
  logic [NB-1:0] lane_d;
  logic          mis_d;
  logic [AW-1:0] st_d;
  logic [AW-1:0] ld_d;
  logic          req_en;
  logic          ld_en;

  assign req_en = req_vld & rst_i_n;
  assign ld_en  = ld_vld & rst_i_n;

  ls_agu_offset #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_ofs (
    .imm   (req_imm),
    .idx   (req_idx),
    .shamt (req_shamt),
    .sel   (req_ofs_sel),
    .ofs   (ofs)
  );

  ls_agu_addr #(.AW(AW)) u_addr (
    .base   (req_base),
    .ofs    (ofs),
    .sub    (req_sub),
    .pre    (req_pre),
    .wb_req (req_wb),
    .addr   (addr_d),
    .wb_val (wbv_d),
    .wb_en  (wben_d)
  );

  ls_agu_lanes #(.AW(AW)) u_lanes (
    .lo       (addr_d[LOW-1:0]),
    .size     (req_size),
    .st_src   (req_st_src),
    .lane_en  (lane_d),
    .misalign (mis_d),
    .st_data  (st_d)
  );

  ls_agu_ldalign #(.AW(AW)) u_ld (
    .raw  (ld_raw),
    .lo   (ld_addr_lo),
    .size (ld_size),
    .sgn  (ld_signed),
    .data (ld_d)
  );

  // next-state
  logic          rsp_vld_n;
  logic [AW-1:0] rsp_addr_n;
  logic [AW-1:0] rsp_wbv_n;
  logic          rsp_wben_n;
  logic [NB-1:0] rsp_lane_n;
  logic          rsp_mis_n;
  logic [AW-1:0] rsp_st_n;
  logic          ld_rdy_n;
  logic [AW-1:0] ld_data_n;

  always_comb begin
    rsp_vld_n  = req_en;
    rsp_addr_n = rsp_addr;
    rsp_wbv_n  = rsp_wb_val;
    rsp_wben_n = rsp_wb_en;
    rsp_lane_n = rsp_lane_en;
    rsp_mis_n  = rsp_misalign;
    rsp_st_n   = rsp_st_data;
    if (req_en) begin
      rsp_addr_n = addr_d;
      rsp_wbv_n  = wbv_d;
      rsp_wben_n = wben_d;
      rsp_lane_n = lane_d;
      rsp_mis_n  = mis_d;
      rsp_st_n   = st_d;
    end
    ld_rdy_n  = ld_en;
    ld_data_n = ld_en ? ld_d : ld_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld      <= 1'b0;
      rsp_addr     <= '0;
      rsp_wb_val   <= '0;
      rsp_wb_en    <= 1'b0;
      rsp_lane_en  <= '0;
      rsp_misalign <= 1'b0;
      rsp_st_data  <= '0;
      ld_rdy       <= 1'b0;
      ld_data      <= '0;
    end else begin
      rsp_vld      <= rsp_vld_n;
      rsp_addr     <= rsp_addr_n;
      rsp_wb_val   <= rsp_wbv_n;
      rsp_wb_en    <= rsp_wben_n;
      rsp_lane_en  <= rsp_lane_n;
      rsp_misalign <= rsp_mis_n;
      rsp_st_data  <= rsp_st_n;
      ld_rdy       <= ld_rdy_n;
      ld_data      <= ld_data_n;
    end
  end

endmodule

// File: rtl/ls_agu_chk.sv
module ls_agu_chk #(
  parameter int AW = 32,
  parameter int NB = AW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic [AW-1:0] req_base,
  input logic          req_pre,
  input logic          req_wb,
  input logic [1:0]    req_size,
  input logic          rsp_vld,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_wb_en,
  input logic [NB-1:0] rsp_lane_en,
  input logic          rsp_misalign,
  input logic          ld_vld,
  input logic [1:0]    ld_size,
  input logic          ld_signed,
  input logic          ld_rdy,
  input logic [AW-1:0] ld_data
);

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(req_vld));

  // R12
  ld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rdy |-> $past(ld_vld));

  // R7
  post_uses_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !$past(req_pre)) |-> (rsp_addr == $past(req_base)));

  // R6
  wb_enable_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_wb_en == (!$past(req_pre) || $past(req_wb))));

  // R8
  byte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && $past(req_size) == 2'd0) |-> !rsp_misalign);

  // R9
  misalign_no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_misalign) |-> (rsp_lane_en == '0));

  // R9
  aligned_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_misalign) |-> ($countones(rsp_lane_en) != 0));

  // R11
  unsigned_byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rdy && $past(ld_size) == 2'd0 && !$past(ld_signed)) |-> (ld_data[AW-1:8] == '0));

endmodule

bind ls_agu ls_agu_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_vld      (req_vld),
  .req_base     (req_base),
  .req_pre      (req_pre),
  .req_wb       (req_wb),
  .req_size     (req_size),
  .rsp_vld      (rsp_vld),
  .rsp_addr     (rsp_addr),
  .rsp_wb_en    (rsp_wb_en),
  .rsp_lane_en  (rsp_lane_en),
  .rsp_misalign (rsp_misalign),
  .ld_vld       (ld_vld),
  .ld_size      (ld_size),
  .ld_signed    (ld_signed),
  .ld_rdy       (ld_rdy),
  .ld_data      (ld_data)
);

// File: tb/sim_ls_agu.sv
module sim_ls_agu;
  localparam int AW   = 32;
  localparam int IMMW = 12;
  localparam int NB   = 4;
  localparam int LOW  = 2;
  localparam int SHW  = 5;

  logic            clk;
  logic            rst_n;
  logic            req_vld;
  logic [AW-1:0]   req_base;
  logic [IMMW-1:0] req_imm;
  logic [AW-1:0]   req_idx;
  logic [SHW-1:0]  req_shamt;
  logic [1:0]      req_ofs_sel;
  logic            req_sub;
  logic            req_pre;
  logic            req_wb;
  logic [1:0]      req_size;
  logic [AW-1:0]   req_st_src;
  logic            rsp_vld;
  logic [AW-1:0]   rsp_addr;
  logic [AW-1:0]   rsp_wb_val;
  logic            rsp_wb_en;
  logic [NB-1:0]   rsp_lane_en;
  logic            rsp_misalign;
  logic [AW-1:0]   rsp_st_data;
  logic            ld_vld;
  logic [AW-1:0]   ld_raw;
  logic [LOW-1:0]  ld_addr_lo;
  logic [1:0]      ld_size;
  logic            ld_signed;
  logic            ld_rdy;
  logic [AW-1:0]   ld_data;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] wbv;
    logic        wben;
    logic [3:0]  lane;
    logic        mis;
    logic [31:0] st;
    logic [31:0] tag;
  } rsp_t;

  typedef struct {
    logic [31:0] data;
    logic [31:0] tag;
  } ld_t;

  rsp_t rsp_q[$];
  ld_t  ld_q[$];

  ls_agu #(.AW(AW), .IMMW(IMMW)) u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected values from the requirements
  function automatic logic [3:0] exp_lane(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 4'b0001 << lo;
    if (sz == 2'd1) return lo[0] ? 4'b0000 : (lo[1] ? 4'b1100 : 4'b0011);
    return (lo == 2'd0) ? 4'b1111 : 4'b0000;
  endfunction

  function automatic logic exp_mis(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return lo[0];
    return lo != 2'd0;
  endfunction

  function automatic logic [31:0] exp_st(input logic [1:0] sz, input logic [31:0] s);
    if (sz == 2'd0) return {4{s[7:0]}};
    if (sz == 2'd1) return {2{s[15:0]}};
    return s;
  endfunction

  task automatic send(input logic [31:0] base, input logic [11:0] imm,
                      input logic [31:0] idx, input logic [4:0] sh,
                      input logic [1:0] sel, input logic sub, input logic pre,
                      input logic wb, input logic [1:0] sz, input logic [31:0] st,
                      input logic [31:0] tag);
    logic [31:0] ofs;
    logic [31:0] moved;
    rsp_t e;
    @(negedge clk);
    req_vld = 1'b1; req_base = base; req_imm = imm; req_idx = idx;
    req_shamt = sh; req_ofs_sel = sel; req_sub = sub; req_pre = pre;
    req_wb = wb; req_size = sz; req_st_src = st;
    if (sel == 2'd0)      ofs = {20'd0, imm};
    else if (sel == 2'd2) ofs = idx << sh;
    else                  ofs = idx;
    moved  = sub ? base - ofs : base + ofs;
    e.addr = pre ? moved : base;
    e.wbv  = moved;
    e.wben = pre ? wb : 1'b1;
    e.lane = exp_lane(sz, e.addr[1:0]);
    e.mis  = exp_mis(sz, e.addr[1:0]);
    e.st   = exp_st(sz, st);
    e.tag  = tag;
    rsp_q.push_back(e);
  endtask

  task automatic send_ld(input logic [31:0] raw, input logic [1:0] lo,
                         input logic [1:0] sz, input logic sgn,
                         input logic [31:0] expv, input logic [31:0] tag);
    ld_t e;
    @(negedge clk);
    ld_vld = 1'b1; ld_raw = raw; ld_addr_lo = lo; ld_size = sz; ld_signed = sgn;
    e.data = expv; e.tag = tag;
    ld_q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      checks++;
      if (rsp_q.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected rsp_vld: actual 1 expected 0");
      end else begin
        rsp_t e;
        e = rsp_q.pop_front();
        if (rsp_addr !== e.addr || rsp_wb_val !== e.wbv || rsp_wb_en !== e.wben ||
            rsp_lane_en !== e.lane || rsp_misalign !== e.mis || rsp_st_data !== e.st) begin
          fails++;
          $display("FAIL %s: actual addr=%h wbv=%h wben=%b lane=%b mis=%b st=%h expected addr=%h wbv=%h wben=%b lane=%b mis=%b st=%h",
                   e.tag, rsp_addr, rsp_wb_val, rsp_wb_en, rsp_lane_en, rsp_misalign, rsp_st_data,
                   e.addr, e.wbv, e.wben, e.lane, e.mis, e.st);
        end
      end
    end
    if (rst_n && ld_rdy) begin
      checks++;
      if (ld_q.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected ld_rdy: actual 1 expected 0");
      end else begin
        ld_t e;
        e = ld_q.pop_front();
        if (ld_data !== e.data) begin
          fails++;
          $display("FAIL %s: actual ld_data=%h expected %h", e.tag, ld_data, e.data);
        end
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_base = '0; req_imm = '0; req_idx = '0;
    req_shamt = '0; req_ofs_sel = '0; req_sub = 1'b0; req_pre = 1'b0;
    req_wb = 1'b0; req_size = '0; req_st_src = '0;
    ld_vld = 1'b0; ld_raw = '0; ld_addr_lo = '0; ld_size = '0; ld_signed = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    checks++;
    if (rsp_vld !== 1'b0 || rsp_addr !== '0 || rsp_wb_en !== 1'b0 || rsp_lane_en !== '0 ||
        ld_rdy !== 1'b0 || ld_data !== '0) begin
      fails++;
      $display("FAIL R12 reset: actual vld=%b addr=%h wben=%b lane=%b rdy=%b data=%h expected all 0",
               rsp_vld, rsp_addr, rsp_wb_en, rsp_lane_en, ld_rdy, ld_data);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    //   base          imm     idx         sh  sel sub pre wb sz  st
    send(32'h0000_1000, 12'h024, 32'h0,       0, 2'd0, 0, 1, 0, 2'd2, 32'h0, "R1"); // R5 too
    send(32'hFFFF_FFFC, 12'h008, 32'h0,       0, 2'd0, 0, 1, 0, 2'd2, 32'h0, "R1"); // wrap to 4
    send(32'h0000_2000, 12'h0,   32'h10,      0, 2'd1, 0, 1, 1, 2'd2, 32'h0, "R2"); // R6
    send(32'h0000_2000, 12'h0,   32'h20,      7, 2'd3, 0, 1, 1, 2'd2, 32'h0, "R2");
    send(32'h0000_3000, 12'h0,   32'h5,       2, 2'd2, 0, 1, 0, 2'd2, 32'h0, "R3");
    send(32'h0000_0000, 12'h0,   32'h1,      31, 2'd2, 0, 1, 1, 2'd0, 32'h0, "R3");
    send(32'h0000_0100, 12'h008, 32'h0,       0, 2'd0, 1, 1, 1, 2'd2, 32'h0, "R4");
    send(32'h0000_0004, 12'h0,   32'h8,       0, 2'd1, 1, 0, 0, 2'd2, 32'h0, "R4"); // wrap below 0
    send(32'h0000_4000, 12'h004, 32'h0,       0, 2'd0, 0, 0, 0, 2'd2, 32'h0, "R7");
    send(32'h0000_4001, 12'h001, 32'h0,       0, 2'd0, 0, 0, 1, 2'd0, 32'h0, "R7");
    send(32'h0000_5001, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd1, 32'h0, "R8"); // half odd
    send(32'h0000_5002, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd2, 32'h0, "R8"); // word off 2
    send(32'h0000_5003, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd3, 32'h0, "R8");
    send(32'h0000_5003, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd0, 32'h0, "R9"); // byte lane 3
    send(32'h0000_5000, 12'h001, 32'h0,       0, 2'd0, 0, 1, 0, 2'd0, 32'h0, "R9"); // byte lane 1
    send(32'h0000_5002, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd1, 32'h0, "R9"); // half upper
    send(32'h0000_5000, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd1, 32'h0, "R9"); // half lower
    send(32'h0000_6000, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd0, 32'hAABBCCDD, "R10");
    send(32'h0000_6000, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd1, 32'hAABBCCDD, "R10");
    send(32'h0000_6000, 12'h0,   32'h0,       0, 2'd0, 0, 1, 0, 2'd2, 32'hAABBCCDD, "R10");
    @(negedge clk);
    req_vld = 1'b0;
    req_base = 32'hDEAD_BEE0;
    repeat (2) @(negedge clk);
    // R12 hold while idle
    checks++;
    if (rsp_vld !== 1'b0 || rsp_st_data !== 32'hAABBCCDD) begin
      fails++;
      $display("FAIL R12 idle: actual vld=%b st=%h expected vld=0 st=aabbccdd", rsp_vld, rsp_st_data);
    end

    send_ld(32'h8070_F0A5, 2'd0, 2'd0, 1'b1, 32'hFFFF_FFA5, "R11");
    send_ld(32'h8070_F0A5, 2'd1, 2'd0, 1'b0, 32'h0000_00F0, "R11");
    send_ld(32'h8070_F0A5, 2'd1, 2'd0, 1'b1, 32'hFFFF_FFF0, "R11");
    send_ld(32'h8070_F0A5, 2'd2, 2'd0, 1'b1, 32'h0000_0070, "R11");
    send_ld(32'h8070_F0A5, 2'd3, 2'd0, 1'b0, 32'h0000_0080, "R11");
    send_ld(32'h8070_F0A5, 2'd2, 2'd1, 1'b1, 32'hFFFF_8070, "R11");
    send_ld(32'h8070_F0A5, 2'd0, 2'd1, 1'b0, 32'h0000_F0A5, "R11");
    send_ld(32'h8070_F0A5, 2'd0, 2'd1, 1'b1, 32'hFFFF_F0A5, "R11");
    send_ld(32'h1234_7FFF, 2'd0, 2'd1, 1'b1, 32'h0000_7FFF, "R11");
    send_ld(32'h8070_F0A5, 2'd0, 2'd2, 1'b1, 32'h8070_F0A5, "R11");
    @(negedge clk);
    ld_vld = 1'b0;
    repeat (3) @(negedge clk);

    // R12 every request answered
    checks++;
    if (rsp_q.size() != 0 || ld_q.size() != 0 || ld_rdy !== 1'b0) begin
      fails++;
      $display("FAIL R12 drain: actual pending=%0d/%0d rdy=%b expected 0/0 rdy=0",
               rsp_q.size(), ld_q.size(), ld_rdy);
    end
    summary();
    $finish;
  end

endmodule